// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Register

This block gathers eight single-bit event lines from a radio transceiver's control logic into one host-readable register. The lines are: power-on reset, crystal ready, low battery, wake-up timer expiry, RSSI over threshold, preamble search timeout, preamble found and sync word found. A companion enable vector arrives as a plain input. It decides, bit by bit, whether a position acts as an interrupt or as a status flag. An interrupt position latches on a rising edge of its event and holds until the host reads the register. A status position simply shows the sampled event level.

An active-low interrupt line is driven from a flop. It is low whenever any enabled position holds a latched event. A host read at the register address returns the value as it stood before the read, and the clock edge that ends the read strobe clears every enabled position. The low-battery position is special: an edge that arrives while the position is masked is kept, and it raises the interrupt as soon as the position is enabled. Edges on any other masked position are discarded.

Top module: `irq_status_reg`

## Requirements
- R1: Read data bit positions: 0 power-on reset, 1 crystal ready, 2 low battery, 3 wake-up timer, 4 RSSI, 5 preamble timeout, 6 preamble found, 7 sync word found.
- R2: A rising edge on an enabled event input latches its bit at the next clock edge, and `irq_n` goes low at that same edge.
- R3: `irq_n` stays low for as long as any enabled bit is latched. Further events do not release it.
- R4: A read strobe at address 0x04 returns the value from before the clear. At the edge ending the strobe, all enabled bits clear and `irq_n` returns high, unless a new edge arrives in that cycle.
- R5: A bit whose enable is 0 reads as the sampled event level, one cycle late. A read does not clear it, and it never pulls `irq_n` low.
- R6: A low-battery edge (bit 2) seen while bit 2 is masked is kept. Enabling bit 2 later pulls `irq_n` low and the bit reads as 1. A masked edge on any other bit is dropped and raises nothing when that bit is enabled.
- R7: An enabled edge arriving in the same cycle as a clearing read wins. Its bit stays set and `irq_n` stays low after the read.
- R8: Host write strobes have no effect on any bit or on `irq_n`, whatever the write data.
- R9: A read strobe at any address other than 0x04 returns 0 and clears nothing.
- R10: After reset, all bits read 0 and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NBITS | Event levels from the control logic |
| evt_en | input | NBITS | Per-bit enable: 1 selects interrupt, 0 selects status |
| host_addr | input | ADDR_W | Host register address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe (ignored) |
| host_wdata | input | NBITS | Host write data (ignored) |
| host_rdata | output | NBITS | Read data, 0 when no read targets this register |
| irq_n | output | 1 | Active-low registered interrupt |

## Verification
The bench goes after the cycle where a fresh enabled edge meets a clearing read. A design that let the clear win would lose that event, and `irq_n` would rise. It also checks a masked low-battery edge followed by enabling the bit, which catches a design that drops it or that keeps masked edges on every bit. Reads of status bits are repeated to catch a design that clears them. Writes and reads at other addresses are applied while a bit is latched, to expose a decoder that clears or sets on the wrong strobe.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
   localparam int IRQS_NBITS    = 8;
   localparam int IRQS_ADDR_W   = 7;
   localparam int IRQS_REG_ADDR = 4;

   localparam int POS_POR      = 0;
   localparam int POS_XTAL_OK  = 1;
   localparam int POS_LOW_BAT  = 2;
   localparam int POS_WAKE     = 3;
   localparam int POS_RSSI     = 4;
   localparam int POS_PRE_TOUT = 5;
   localparam int POS_PRE_OK   = 6;
   localparam int POS_SYNC     = 7;

   localparam logic [IRQS_NBITS-1:0] IRQS_HOLD_MASK = IRQS_NBITS'(1) << POS_LOW_BAT;
endpackage

// File: rtl/irqs_edge.sv
module irqs_edge #(
   parameter int NBITS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBITS-1:0] evt_in,
   output logic [NBITS-1:0] lvl,
   output logic [NBITS-1:0] rise
);
   logic [NBITS-1:0] smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= '0;
      else        smp_q <= evt_in;
   end

   assign lvl  = smp_q;
   assign rise = evt_in & ~smp_q;
endmodule

// File: rtl/irqs_bit_cell.sv
module irqs_bit_cell #(
   parameter bit HOLD_MASKED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise,
   input  logic en,
   input  logic clr,
   output logic lat_q,
   output logic lat_d,
   output logic stat
);
   generate
      if (HOLD_MASKED) begin : g_hold
         always_comb begin
            if (rise)            lat_d = 1'b1;
            else if (clr && en)  lat_d = 1'b0;
            else                 lat_d = lat_q;
         end

         // R6: masked edge kept for later
         a_r6_kept_masked: assert property (@(posedge clk) disable iff (!rst_n)
            rise && !en |=> lat_q);
      end else begin : g_plain
         always_comb begin
            if (!en)       lat_d = 1'b0;
            else if (rise) lat_d = 1'b1;
            else if (clr)  lat_d = 1'b0;
            else           lat_d = lat_q;
         end

         // R6: masked edge on ordinary bit is dropped
         a_r6_masked_dropped: assert property (@(posedge clk) disable iff (!rst_n)
            !en |=> !lat_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= 1'b0;
      else        lat_q <= lat_d;
   end

   assign stat = en ? lat_q : lvl;

   a_r2_rise_latches: assert property (@(posedge clk) disable iff (!rst_n)
      rise && en |=> lat_q);

   a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr && en && !rise |=> !lat_q);

   a_r7_event_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
      clr && en && rise |=> lat_q);
endmodule

// File: rtl/irqs_rdport.sv
module irqs_rdport #(
   parameter int NBITS    = 8,
   parameter int ADDR_W   = 7,
   parameter int REG_ADDR = 4
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd,
   input  logic [NBITS-1:0]  stat,
   output logic              rd_hit,
   output logic [NBITS-1:0]  rdata
);
   localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

   assign rd_hit = host_rd && (host_addr == MY_ADDR);
   assign rdata  = rd_hit ? stat : '0;
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
   parameter int                 NBITS     = irqs_pkg::IRQS_NBITS,
   parameter int                 ADDR_W    = irqs_pkg::IRQS_ADDR_W,
   parameter int                 REG_ADDR  = irqs_pkg::IRQS_REG_ADDR,
   parameter logic [NBITS-1:0]   HOLD_MASK = irqs_pkg::IRQS_HOLD_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NBITS-1:0]  evt_in,
   input  logic [NBITS-1:0]  evt_en,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_rd,
   input  logic              host_wr,
   input  logic [NBITS-1:0]  host_wdata,
   output logic [NBITS-1:0]  host_rdata,
   output logic              irq_n
);
   localparam longint ADDR_SPAN = longint'(1) << ADDR_W;

   generate
      if (NBITS < 1 || NBITS > 32) begin : g_bad_width
         $error("irq_status_reg: NBITS must be within 1..32");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("irq_status_reg: ADDR_W must be within 1..16");
      end
      if (REG_ADDR < 0 || longint'(REG_ADDR) >= ADDR_SPAN) begin : g_bad_addr
         $error("irq_status_reg: REG_ADDR outside address space");
      end
   endgenerate

   logic [NBITS-1:0] lvl_w, rise_w, lat_q, lat_d, stat_w;
   logic             rd_hit;
   logic             irq_nq;

   irqs_edge #(.NBITS(NBITS)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .evt_in (evt_in),
      .lvl    (lvl_w),
      .rise   (rise_w)
   );

   irqs_rdport #(.NBITS(NBITS), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) rdport_i (
      .host_addr (host_addr),
      .host_rd   (host_rd),
      .stat      (stat_w),
      .rd_hit    (rd_hit),
      .rdata     (host_rdata)
   );

   for (genvar gi = 0; gi < NBITS; gi++) begin : g_bit
      irqs_bit_cell #(.HOLD_MASKED(HOLD_MASK[gi])) cell_i (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (lvl_w[gi]),
         .rise  (rise_w[gi]),
         .en    (evt_en[gi]),
         .clr   (rd_hit),
         .lat_q (lat_q[gi]),
         .lat_d (lat_d[gi]),
         .stat  (stat_w[gi])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_nq <= 1'b1;
      else        irq_nq <= ~|(lat_d & evt_en);
   end

   assign irq_n = irq_nq;

   // R3: enabled latched bit without a read keeps the line low
   a_r3_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
      (|(lat_q & evt_en)) && !rd_hit |=> !irq_n);

   // R4: clean read releases the line
   a_r4_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hit && !(|rise_w) |=> irq_n);

   // R8: a write with zero data clears nothing
   a_r8_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !rd_hit && (~|host_wdata)
      |=> ((lat_q & $past(lat_q & evt_en)) == $past(lat_q & evt_en)));

   // R8: a write with set bits sets nothing
   a_r8_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      host_wr && !rd_hit && (|host_wdata) && !(|rise_w)
      |=> ((lat_q & ~$past(lat_q)) == '0));

   // R9: foreign-address read leaves enabled bits intact
   a_r9_foreign_read: assert property (@(posedge clk) disable iff (!rst_n)
      host_rd && !rd_hit |=> ((lat_q & $past(lat_q & evt_en)) == $past(lat_q & evt_en)));
endmodule

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb_top;
   import irqs_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] evt_in = '0;
   logic [7:0] evt_en = '0;
   logic [6:0] host_addr = '0;
   logic       host_rd = 1'b0;
   logic       host_wr = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic       irq_n;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   irq_status_reg dut_i (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_en(evt_en),
      .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .irq_n(irq_n)
   );

   localparam logic [7:0] M_POR  = 8'(1) << POS_POR;
   localparam logic [7:0] M_XTAL = 8'(1) << POS_XTAL_OK;
   localparam logic [7:0] M_BAT  = 8'(1) << POS_LOW_BAT;
   localparam logic [7:0] M_WAKE = 8'(1) << POS_WAKE;
   localparam logic [7:0] M_RSSI = 8'(1) << POS_RSSI;
   localparam logic [7:0] M_TOUT = 8'(1) << POS_PRE_TOUT;
   localparam logic [7:0] M_PRE  = 8'(1) << POS_PRE_OK;
   localparam logic [7:0] M_SYNC = 8'(1) << POS_SYNC;

   // monitor: pops expected read data as reads happen
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (host_rd) begin
            if (exp_q.size() == 0) begin
               errors++;
               $display("FAIL unexpected read: actual %h expected none", host_rdata);
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               checks++;
               if (host_rdata !== e) begin
                  errors++;
                  $display("FAIL %s rdata: actual %h expected %h", t, host_rdata, e);
               end
            end
         end
      end
   end

   task automatic do_read(input logic [6:0] a, input logic [7:0] e, input string t);
      @(negedge clk);
      host_addr = a;
      host_rd = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      evt_in = evt_in | m;
      @(negedge clk);
      evt_in = evt_in & ~m;
   endtask

   task automatic check_irq(input logic e, input string t);
      checks++;
      if (irq_n !== e) begin
         errors++;
         $display("FAIL %s irq_n: actual %b expected %b", t, irq_n, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_irq(1'b1, "R10");
      do_read(7'h04, 8'h00, "R10");

      // R2 / R1: sync word bit, enabled
      evt_en = 8'hFF;
      pulse(M_SYNC);
      check_irq(1'b0, "R2");
      do_read(7'h04, 8'h80, "R1");
      check_irq(1'b1, "R4");
      do_read(7'h04, 8'h00, "R4");

      // R3: back-to-back events keep the line low
      pulse(M_PRE);
      pulse(M_TOUT);
      check_irq(1'b0, "R3");
      do_read(7'h04, M_PRE | M_TOUT, "R3");
      check_irq(1'b1, "R4");

      // R5: status bit follows level, not cleared by read
      evt_en = 8'h00;
      @(negedge clk);
      evt_in = M_RSSI;
      @(negedge clk);
      check_irq(1'b1, "R5");
      do_read(7'h04, M_RSSI, "R5");
      do_read(7'h04, M_RSSI, "R5");
      evt_in = '0;
      @(negedge clk);
      do_read(7'h04, 8'h00, "R5");

      // R6: low battery kept while masked
      pulse(M_BAT);
      check_irq(1'b1, "R6");
      do_read(7'h04, 8'h00, "R6");
      evt_en = M_BAT;
      @(negedge clk);
      check_irq(1'b0, "R6");
      do_read(7'h04, M_BAT, "R6");
      check_irq(1'b1, "R6");

      // R6: masked wake-up edge is discarded
      evt_en = 8'h00;
      pulse(M_WAKE);
      evt_en = M_WAKE;
      @(negedge clk);
      check_irq(1'b1, "R6");
      do_read(7'h04, 8'h00, "R6");

      // R7: edge in the cycle of a clearing read wins
      evt_en = 8'hFF;
      pulse(M_POR);
      check_irq(1'b0, "R7");
      @(negedge clk);
      host_addr = 7'h04;
      host_rd = 1'b1;
      exp_q.push_back(M_POR);
      tag_q.push_back("R7");
      evt_in = M_XTAL;
      @(negedge clk);
      host_rd = 1'b0;
      evt_in = '0;
      check_irq(1'b0, "R7");
      do_read(7'h04, M_XTAL, "R7");
      check_irq(1'b1, "R7");

      // R8: writes ignored
      pulse(M_TOUT);
      @(negedge clk);
      host_addr = 7'h04; host_wr = 1'b1; host_wdata = 8'h00;
      @(negedge clk);
      host_wr = 1'b0;
      check_irq(1'b0, "R8");
      do_read(7'h04, M_TOUT, "R8");
      @(negedge clk);
      host_wr = 1'b1; host_wdata = 8'hFF;
      @(negedge clk);
      host_wr = 1'b0;
      @(negedge clk);
      check_irq(1'b1, "R8");
      do_read(7'h04, 8'h00, "R8");

      // R9: read elsewhere returns 0 and clears nothing
      pulse(M_PRE);
      do_read(7'h05, 8'h00, "R9");
      check_irq(1'b0, "R9");
      do_read(7'h04, M_PRE, "R9");

      // R5 / R4: mixed enable
      evt_en = 8'h0F;
      @(negedge clk);
      evt_in = M_WAKE | M_RSSI;
      @(negedge clk);
      evt_in = M_RSSI;
      @(negedge clk);
      check_irq(1'b0, "R2");
      do_read(7'h04, M_WAKE | M_RSSI, "R5");
      check_irq(1'b1, "R4");
      do_read(7'h04, M_RSSI, "R5");
      evt_in = '0;

      repeat (3) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule